// File: doc/BRIEF.md
# File-Register Clear/Complement Unit

This unit carries out three byte-wide operations on a small register file and a working register (W): clear W, clear an addressed file entry, and complement an addressed file entry. A complement can send its result either back to the entry it read or into W. Every operation also updates a zero flag. Clears always set the flag. A complement sets it only when the inverted byte is zero.

An operation is issued by raising `start` for one cycle, together with an opcode, a file address and a destination bit. The file entry is read, the result is formed and written, and W and the zero flag are updated, all in that same cycle. The file has a second, read-only observation port with registered data. Through it the surrounding logic, or a bench, can see any entry without disturbing an operation.

Top module: `regop_unit`

## Requirements
- R1: After synchronous reset, `w_q` is 00h, `z_q` is 0 and every file entry reads 00h on the observation port.
- R2: CLRF (opcode 2'b01) writes 00h to file entry `addr` and sets `z_q` to 1. `w_q` holds its value and `dest` has no effect.
- R3: CLRW (opcode 2'b00) writes 00h to `w_q` and sets `z_q` to 1. No file entry changes, and `addr` and `dest` have no effect.
- R4: COMF (opcode 2'b10) with `dest`=1 writes the bitwise inverse of entry `addr` back into that entry. `w_q` holds its value.
- R5: COMF with `dest`=0 writes the bitwise inverse of entry `addr` into `w_q`. No file entry changes.
- R6: After COMF, `z_q` is 1 when the 8-bit inverted value is 00h and 0 otherwise.
- R7: With `start`=0, or with the unused opcode 2'b11, neither `w_q`, `z_q` nor any file entry changes.
- R8: Each operation completes in one cycle. Its results are visible after the clock edge that samples `start`, and an operation issued in the very next cycle already sees them.
- R9: `obs_data` shows entry `obs_addr` one cycle after it is presented. If the same edge also writes that entry, `obs_data` shows the value from before the write.
- R10: An operation changes only its own target. All other file entries, including addresses 0 and 31, keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue the operation described by the other inputs this cycle |
| opcode | input | 2 | 00 CLRW, 01 CLRF, 10 COMF, 11 unused |
| addr | input | 5 | File entry operand, 0 to 31 |
| dest | input | 1 | COMF result target: 0 to W, 1 to the file entry |
| obs_addr | input | 5 | Observation read address |
| obs_data | output | 8 | Registered contents of entry `obs_addr` |
| w_q | output | 8 | Working register |
| z_q | output | 1 | Zero flag |

## Verification
A corrupted file entry stays hidden until a COMF reads it or the observation port is pointed at it. A complement to W exposes the bad byte on `w_q` and `z_q` one cycle later, and the observation port shows it one cycle after its address is presented. A mis-decoded destination or zero flag appears on `w_q` or `z_q` at the very next edge. For that reason the reference model compares all three outputs on every cycle and ends with a sweep of all 32 entries, so no stale entry goes unread.

// File: rtl/regop_pkg.sv
package regop_pkg;

  typedef enum logic [1:0] {
    OP_CLRW = 2'b00,
    OP_CLRF = 2'b01,
    OP_COMF = 2'b10,
    OP_NONE = 2'b11
  } regop_e;

  typedef struct packed {
    logic wr_file;
    logic wr_w;
    logic upd_z;
    logic use_inv;
  } regop_ctrl_t;

  localparam regop_ctrl_t CTRL_IDLE = '{wr_file: 1'b0, wr_w: 1'b0, upd_z: 1'b0, use_inv: 1'b0};

endpackage

// File: rtl/regop_decode.sv
module regop_decode
  import regop_pkg::*;
(
  input  logic        start,
  input  logic [1:0]  opcode,
  input  logic        dest,
  output regop_ctrl_t ctrl
);

  regop_e op;
  assign op = regop_e'(opcode);

  always_comb begin
    ctrl = CTRL_IDLE;
    if (start) begin
      unique case (op)
        OP_CLRW: begin
          ctrl.wr_w  = 1'b1;
          ctrl.upd_z = 1'b1;
        end
        OP_CLRF: begin
          ctrl.wr_file = 1'b1;
          ctrl.upd_z   = 1'b1;
        end
        OP_COMF: begin
          ctrl.use_inv = 1'b1;
          ctrl.upd_z   = 1'b1;
          ctrl.wr_file = dest;
          ctrl.wr_w    = ~dest;
        end
        default: ctrl = CTRL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/regop_alu.sv
module regop_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              use_inv,
  output logic [DATA_W-1:0] result,
  output logic              zero
);

  always_comb begin
    if (use_inv) result = ~operand;
    else         result = '0;
  end

  assign zero = (result == '0);

endmodule

// File: rtl/regop_file.sv
module regop_file #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] obs_addr,
  output logic [DATA_W-1:0] obs_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  valid_q;

  // Storage has no reset so it maps onto distributed RAM; per-entry valid
  // bits make never-written entries read as zero after reset.
  always_ff @(posedge clk) begin
    if (wr_en) mem[op_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        valid_q <= '0;
    else if (wr_en) valid_q[op_addr] <= 1'b1;
  end

  assign op_data = valid_q[op_addr] ? mem[op_addr] : '0;

  always_ff @(posedge clk) begin
    if (rst)                    obs_data <= '0;
    else if (valid_q[obs_addr]) obs_data <= mem[obs_addr];
    else                        obs_data <= '0;
  end

endmodule

// File: rtl/regop_unit.sv
module regop_unit
  import regop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        opcode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dest,
  input  logic [ADDR_W-1:0] obs_addr,
  output logic [DATA_W-1:0] obs_data,
  output logic [DATA_W-1:0] w_q,
  output logic              z_q
);

  regop_ctrl_t       ctrl;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] res;
  logic              res_zero;

  regop_decode u_dec (
    .start  (start),
    .opcode (opcode),
    .dest   (dest),
    .ctrl   (ctrl)
  );

  regop_file #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_file (
    .clk      (clk),
    .rst      (rst),
    .op_addr  (addr),
    .op_data  (rd_val),
    .wr_en    (ctrl.wr_file),
    .wr_data  (res),
    .obs_addr (obs_addr),
    .obs_data (obs_data)
  );

  regop_alu #(.DATA_W(DATA_W)) u_alu (
    .operand (rd_val),
    .use_inv (ctrl.use_inv),
    .result  (res),
    .zero    (res_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q <= '0;
      z_q <= 1'b0;
    end else begin
      if (ctrl.wr_w)  w_q <= res;
      if (ctrl.upd_z) z_q <= res_zero;
    end
  end

endmodule

// File: rtl/regop_chk.sv
module regop_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [1:0]        opcode,
  input logic              dest,
  input logic [DATA_W-1:0] w_q,
  input logic              z_q
);

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (w_q == '0 && !z_q)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(w_q) && $stable(z_q))); // R7
  AST_UNUSED_OP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (start && opcode == 2'b11) |=> ($stable(w_q) && $stable(z_q))); // R7
  AST_CLRW_RESULT: assert property (@(posedge clk) disable iff (rst)
    (start && opcode == 2'b00) |=> (w_q == '0 && z_q)); // R3
  AST_CLRF_FLAG: assert property (@(posedge clk) disable iff (rst)
    (start && opcode == 2'b01) |=> (z_q && $stable(w_q))); // R2
  AST_COMF_FILE_W_HOLD: assert property (@(posedge clk) disable iff (rst)
    (start && opcode == 2'b10 && dest) |=> $stable(w_q)); // R4
  AST_COMF_W_ZERO: assert property (@(posedge clk) disable iff (rst)
    (start && opcode == 2'b10 && !dest) |=> (z_q == (w_q == '0))); // R6

endmodule

bind regop_unit regop_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .opcode (opcode),
  .dest   (dest),
  .w_q    (w_q),
  .z_q    (z_q)
);

// File: tb/sim_regop_unit.sv
`timescale 1ns/1ps
module sim_regop_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] opcode = 2'b11;
  logic [4:0] addr = '0;
  logic       dest = 1'b0;
  logic [4:0] obs_addr = '0;
  logic [7:0] obs_data;
  logic [7:0] w_q;
  logic       z_q;

  always #4 clk = ~clk;

  regop_unit u0 (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .addr(addr),
    .dest(dest), .obs_addr(obs_addr), .obs_data(obs_data), .w_q(w_q), .z_q(z_q)
  );

  int checks = 0;
  int fails = 0;
  string cur_tag = "R1";
  string cur_obs_tag = "R1";
  string chk_tag = "R1";
  string chk_obs_tag = "R1";
  bit armed = 1'b0;
  bit done = 1'b0;

  logic [7:0] m_mem [32];
  logic [7:0] m_w, m_obs, r;
  logic       m_z;

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_w = 8'h00; m_z = 1'b0; m_obs = 8'h00;
      for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
    end else begin
      m_obs = m_mem[obs_addr];
      if (start) begin
        case (opcode)
          2'b00: begin m_w = 8'h00; m_z = 1'b1; end
          2'b01: begin m_mem[addr] = 8'h00; m_z = 1'b1; end
          2'b10: begin
            r = ~m_mem[addr];
            if (dest) m_mem[addr] = r; else m_w = r;
            m_z = (r == 8'h00);
          end
          default: ;
        endcase
      end
    end
    chk_tag = cur_tag;
    chk_obs_tag = cur_obs_tag;
    armed = 1'b1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (w_q !== m_w) begin
        fails++;
        $display("FAIL %s w_q actual=%h expected=%h", chk_tag, w_q, m_w);
      end
      checks++;
      if (z_q !== m_z) begin
        fails++;
        $display("FAIL %s z_q actual=%b expected=%b",
                 (chk_tag == "R4" || chk_tag == "R5") ? "R6" : chk_tag, z_q, m_z);
      end
      checks++;
      if (obs_data !== m_obs) begin
        fails++;
        $display("FAIL %s obs_data actual=%h expected=%h", chk_obs_tag, obs_data, m_obs);
      end
    end
  end

  task automatic issue(input bit s, input logic [1:0] op, input logic [4:0] a,
                       input bit d, input string tag);
    @(posedge clk); #1;
    start = s; opcode = op; addr = a; dest = d; obs_addr = a;
    cur_tag = tag; cur_obs_tag = "R9";
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); #1;
      start = 1'b0; obs_addr = 5'(i); cur_tag = tag; cur_obs_tag = tag;
    end
    @(posedge clk); #1;
  endtask

  task automatic report();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    sweep("R1");
    issue(1, 2'b00, 5'd3, 1, "R3");      // CLRW ignores addr/dest
    issue(1, 2'b10, 5'd5, 1, "R4");      // entry5 -> FF, z=0
    issue(1, 2'b10, 5'd5, 0, "R5");      // W = 00, z=1
    issue(1, 2'b10, 5'd5, 1, "R4");      // entry5 -> 00, z=1
    issue(1, 2'b10, 5'd7, 1, "R8");      // back-to-back on entry 7
    issue(1, 2'b10, 5'd7, 0, "R8");      // sees FF, W = 00
    issue(1, 2'b10, 5'd9, 0, "R5");      // W = FF, z=0
    issue(1, 2'b01, 5'd7, 0, "R2");      // CLRF, W stays FF
    issue(1, 2'b11, 5'd9, 1, "R7");      // unused opcode
    issue(0, 2'b10, 5'd9, 0, "R7");      // start low
    issue(1, 2'b10, 5'd0, 1, "R10");     // boundary entries
    issue(1, 2'b10, 5'd31, 1, "R10");
    issue(1, 2'b00, 5'd31, 0, "R3");
    issue(1, 2'b10, 5'd31, 0, "R5");
    for (int n = 0; n < 600; n++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      issue(($urandom_range(0, 7) != 0), op, 5'($urandom_range(0, 31)),
            1'($urandom_range(0, 1)),
            (op == 2'b00) ? "R3" : (op == 2'b01) ? "R2" : (op == 2'b10) ? "R6" : "R7");
      if (n % 3 == 0) obs_addr = 5'($urandom_range(0, 31));
    end
    sweep("R10");
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

endmodule